// File: doc/BRIEF.md
# Translation Permission and Fault-Code Checker

This block judges one memory access against the attribute bits of the leaf page-table entry that translated it. The access can be a load, a store or an instruction fetch. The block returns an allow or deny decision, the architected fault status word and the fault address. For data accesses the status word is the data-storage status value. For fetches it is the cause bits of the saved machine state, merged with the machine-state bits supplied by the core. A deny tells the pipeline to suppress the store or leave the load destination unchanged.

Causes are ranked. A missing translation outranks everything else. Next comes a permission failure: the read, write or execute bit is clear, or a privileged page is accessed in user mode. Last comes a missing referenced or changed bit. The checker reports that as a fault of its own and never sets the bit itself. When the attributes belong to the page that follows the one the access started in, the fault address is the base of that following page.

The block registers its decision once. The response appears one clock after the request.

Top module: `xlate_perm_check`

## Requirements
- R1: While reset (rstN low) is asserted, and after it, until the first request, rspValid, rspAllow and rspDeny are 0, and rspStatus and rspFaultAddr are all zero.
- R2: A request presented with reqValid high at a rising edge gives rspValid high after that edge. Without a request, rspValid, rspAllow and rspDeny are 0 and rspStatus and rspFaultAddr are zero.
- R3: Access kind code 0 is a load. Attribute bit 2 is the read permission. A translated load with bit 2 clear is denied with status 0x08000000.
- R4: Kind code 1 is a store. Attribute bit 1 is the write permission. A translated store with bit 1 clear is denied with status 0x0A000000, which is the permission code plus the store marker 0x02000000.
- R5: Attribute bit 8 is referenced and bit 7 is changed. A permitted load with bit 8 clear gives status 0x00040000. A permitted store with bit 8 or bit 7 clear gives 0x02040000. Both cases are denied, and a permission failure masks this code.
- R6: Kind codes 2 and 3 are fetches. Attribute bit 0 is execute permission. A fetch with bit 0 clear gives 0x10000000. A fetch with bit 0 set and bit 8 clear gives 0x00040000. When both bits are clear, only 0x10000000 is reported. Every denied fetch ORs msrBits into the status.
- R7: With pteValid low, any access is denied. A load gives 0x40000000, a store gives 0x42000000, and a fetch gives 0x40000000 ORed with msrBits.
- R8: Attribute bit 3 marks a privileged page. With userMode high, an access to such a page gets the permission code of its kind: 0x08000000 for a load, 0x0A000000 for a store, 0x10000000 plus msrBits for a fetch.
- R9: Exactly one of rspAllow and rspDeny is high with each response. An allowed access returns a zero status and a zero fault address.
- R10: The fault address of a denied access is reqAddr. With reqNextPage high, it is reqAddr rounded down to a 2^PAGE_SHIFT boundary plus 2^PAGE_SHIFT, wrapping modulo 2^ADDR_W.
- R11: The non-cacheable bit (bit 5), bits 4 and 6, and any bits above 8 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqKind | input | 2 | 0 load, 1 store, 2 or 3 fetch |
| pteValid | input | 1 | A leaf entry was found for the address |
| pteAttr | input | ATTR_W | Attribute bits of the leaf entry |
| userMode | input | 1 | Access made in user (unprivileged) mode |
| reqNextPage | input | 1 | The attributes describe the page following the one reqAddr lies in |
| reqAddr | input | ADDR_W | Effective address of the access |
| msrBits | input | STATUS_W | Machine-state bits merged into a fetch fault word |
| rspValid | output | 1 | Response present |
| rspAllow | output | 1 | Access permitted |
| rspDeny | output | 1 | Access refused; suppress the write or keep the load target |
| rspStatus | output | STATUS_W | Fault status word, zero when allowed |
| rspFaultAddr | output | ADDR_W | Fault address, zero when allowed |

## Verification
The bench builds the block with ATTR_W=9, ADDR_W=64, STATUS_W=64 and PAGE_SHIFT=12. With these values the whole 64-bit machine-state word goes through the fetch merge, so the sign bit and the low bits of msrBits are both seen in the result. The next-page rule works at 4 KiB boundaries, including the wrap from the top of the address space to zero. A behavioural model in the bench compares every cycle over directed cause combinations, including masked double faults and privileged pages, and a long random run.

// File: rtl/pchk_pkg.sv
package pchk_pkg;

  typedef enum logic [1:0] {
    KIND_LOAD      = 2'd0,
    KIND_STORE     = 2'd1,
    KIND_FETCH     = 2'd2,
    KIND_FETCH_ALT = 2'd3
  } accKind_e;

  // attribute bit positions (decoded by the page-table walker's producer)
  localparam int ATTR_EXEC    = 0;
  localparam int ATTR_WRITE   = 1;
  localparam int ATTR_READ    = 2;
  localparam int ATTR_PRIV    = 3;
  localparam int ATTR_NOCACHE = 5;
  localparam int ATTR_CHANGED = 7;
  localparam int ATTR_REFD    = 8;
  localparam int ATTR_MIN_W   = 9;

  localparam int CODE_W = 32;
  localparam logic [CODE_W-1:0] CODE_NO_XLATE   = 32'h4000_0000;
  localparam logic [CODE_W-1:0] CODE_FETCH_PERM = 32'h1000_0000;
  localparam logic [CODE_W-1:0] CODE_DATA_PERM  = 32'h0800_0000;
  localparam logic [CODE_W-1:0] CODE_STORE_MARK = 32'h0200_0000;
  localparam logic [CODE_W-1:0] CODE_REF_CHG    = 32'h0004_0000;
  localparam int STORE_MARK_BIT = 25;

  typedef struct packed {
    logic capture;
    logic isStore;
    logic isFetch;
    logic faultNoXlate;
    logic faultPerm;
    logic faultRefChg;
    logic useNextPage;
  } ctlStrobe_t;

endpackage

// File: rtl/pchk_ctrl.sv
module pchk_ctrl
  import pchk_pkg::*;
#(
  parameter int ATTR_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic              pteValid,
  input  logic [ATTR_W-1:0] pteAttr,
  input  logic              userMode,
  input  logic              reqNextPage,
  output ctlStrobe_t        strobe
);

  logic isFetch, isStore, isLoad;
  logic permBit, privBlock, permOk, refChgOk;

  assign isFetch = reqKind[1];
  assign isStore = (reqKind == KIND_STORE);
  assign isLoad  = (reqKind == KIND_LOAD);

  always_comb begin
    permBit = 1'b0;
    if (isFetch)      permBit = pteAttr[ATTR_EXEC];
    else if (isStore) permBit = pteAttr[ATTR_WRITE];
    else if (isLoad)  permBit = pteAttr[ATTR_READ];
  end

  assign privBlock = pteAttr[ATTR_PRIV] & userMode;
  assign permOk    = permBit & ~privBlock;
  assign refChgOk  = pteAttr[ATTR_REFD] & (~isStore | pteAttr[ATTR_CHANGED]);

  always_comb begin
    strobe              = '0;
    strobe.capture      = reqValid;
    strobe.isStore      = isStore;
    strobe.isFetch      = isFetch;
    strobe.useNextPage  = reqNextPage;
    strobe.faultNoXlate = ~pteValid;
    strobe.faultPerm    = pteValid & ~permOk;
    strobe.faultRefChg  = pteValid & permOk & ~refChgOk;
  end

  // bits that must not steer the decision (R11)
  logic attrUnusedLo;
  assign attrUnusedLo = ^{pteAttr[ATTR_NOCACHE], pteAttr[4], pteAttr[6]};
  generate
    if (ATTR_W > ATTR_MIN_W) begin : g_wideAttr
      logic attrUnusedHi;
      assign attrUnusedHi = ^pteAttr[ATTR_W-1:ATTR_MIN_W];
    end
  endgenerate

  a_r5_single_cause: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> $onehot0({strobe.faultNoXlate, strobe.faultPerm, strobe.faultRefChg}));

  a_r6_exec_masks_ref: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && isFetch && pteValid && !pteAttr[ATTR_EXEC]) |-> !strobe.faultRefChg);

  a_r7_noxlate_first: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !pteValid) |-> (!strobe.faultPerm && !strobe.faultRefChg));

endmodule

// File: rtl/pchk_dp.sv
module pchk_dp
  import pchk_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int STATUS_W   = 64,
  parameter int PAGE_SHIFT = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strobe,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [STATUS_W-1:0] msrBits,
  output logic                rspValid,
  output logic                rspAllow,
  output logic                rspDeny,
  output logic [STATUS_W-1:0] rspStatus,
  output logic [ADDR_W-1:0]   rspFaultAddr
);

  localparam logic [ADDR_W-1:0] PAGE_BYTES  = {{(ADDR_W-1){1'b0}}, 1'b1} << PAGE_SHIFT;
  localparam logic [ADDR_W-1:0] OFFSET_MASK = PAGE_BYTES - 1'b1;

  logic                anyFault;
  logic [CODE_W-1:0]   causeCode;
  logic [STATUS_W-1:0] causeWide, statusNext;
  logic [ADDR_W-1:0]   nextPageBase, addrNext;

  assign anyFault = strobe.faultNoXlate | strobe.faultPerm | strobe.faultRefChg;

  always_comb begin
    causeCode = '0;
    if (strobe.faultNoXlate) causeCode = CODE_NO_XLATE;
    if (strobe.faultPerm)    causeCode = strobe.isFetch ? CODE_FETCH_PERM : CODE_DATA_PERM;
    if (strobe.faultRefChg)  causeCode = CODE_REF_CHG;
    if (strobe.isStore && anyFault) causeCode = causeCode | CODE_STORE_MARK;
  end

  generate
    if (STATUS_W > CODE_W) begin : g_padStatus
      assign causeWide = {{(STATUS_W-CODE_W){1'b0}}, causeCode};
    end else begin : g_exactStatus
      assign causeWide = causeCode;
    end
  endgenerate

  assign statusNext   = anyFault ? (causeWide | (strobe.isFetch ? msrBits : '0)) : '0;
  assign nextPageBase = (reqAddr & ~OFFSET_MASK) + PAGE_BYTES;
  assign addrNext     = anyFault ? (strobe.useNextPage ? nextPageBase : reqAddr) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid     <= 1'b0;
      rspAllow     <= 1'b0;
      rspDeny      <= 1'b0;
      rspStatus    <= '0;
      rspFaultAddr <= '0;
    end else begin
      rspValid     <= strobe.capture;
      rspAllow     <= strobe.capture & ~anyFault;
      rspDeny      <= strobe.capture & anyFault;
      rspStatus    <= strobe.capture ? statusNext : '0;
      rspFaultAddr <= strobe.capture ? addrNext : '0;
    end
  end

  a_r2_response_follows: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> rspValid);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!rspAllow && !rspDeny && rspStatus == '0));

  a_r9_one_verdict: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspAllow != rspDeny));

  a_r9_allow_clean: assert property (@(posedge clk) disable iff (!rstN)
    rspAllow |-> (rspStatus == '0 && rspFaultAddr == '0));

  a_r4_store_marked: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && strobe.isStore && anyFault) |=> rspStatus[STORE_MARK_BIT]);

  a_r10_page_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && strobe.useNextPage && anyFault) |=> (rspFaultAddr[PAGE_SHIFT-1:0] == '0));

endmodule

// File: rtl/xlate_perm_check.sv
module xlate_perm_check
  import pchk_pkg::*;
#(
  parameter int ATTR_W     = 9,
  parameter int ADDR_W     = 64,
  parameter int STATUS_W   = 64,
  parameter int PAGE_SHIFT = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [1:0]          reqKind,
  input  logic                pteValid,
  input  logic [ATTR_W-1:0]   pteAttr,
  input  logic                userMode,
  input  logic                reqNextPage,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [STATUS_W-1:0] msrBits,
  output logic                rspValid,
  output logic                rspAllow,
  output logic                rspDeny,
  output logic [STATUS_W-1:0] rspStatus,
  output logic [ADDR_W-1:0]   rspFaultAddr
);

  ctlStrobe_t strobe;

  pchk_ctrl #(.ATTR_W(ATTR_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqKind    (reqKind),
    .pteValid   (pteValid),
    .pteAttr    (pteAttr),
    .userMode   (userMode),
    .reqNextPage(reqNextPage),
    .strobe     (strobe)
  );

  pchk_dp #(.ADDR_W(ADDR_W), .STATUS_W(STATUS_W), .PAGE_SHIFT(PAGE_SHIFT)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqAddr     (reqAddr),
    .msrBits     (msrBits),
    .rspValid    (rspValid),
    .rspAllow    (rspAllow),
    .rspDeny     (rspDeny),
    .rspStatus   (rspStatus),
    .rspFaultAddr(rspFaultAddr)
  );

endmodule

// File: tb/sim_xlate_perm_check.sv
`timescale 1ns/1ps
module sim_xlate_perm_check;

  logic        clk = 0;
  logic        rstN = 0;
  logic        reqValid = 0;
  logic [1:0]  reqKind = 0;
  logic        pteValid = 0;
  logic [8:0]  pteAttr = 0;
  logic        userMode = 0;
  logic        reqNextPage = 0;
  logic [63:0] reqAddr = 0;
  logic [63:0] msrBits = 0;
  logic        rspValid, rspAllow, rspDeny;
  logic [63:0] rspStatus, rspFaultAddr;

  int checks = 0;
  int errors = 0;
  string phase = "R2";

  always #10 clk = ~clk;

  xlate_perm_check u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .pteValid(pteValid), .pteAttr(pteAttr), .userMode(userMode),
    .reqNextPage(reqNextPage), .reqAddr(reqAddr), .msrBits(msrBits),
    .rspValid(rspValid), .rspAllow(rspAllow), .rspDeny(rspDeny),
    .rspStatus(rspStatus), .rspFaultAddr(rspFaultAddr)
  );

  localparam logic [63:0] MSR_RUN = 64'h8000_0000_0000_0021;

  // behavioural reference
  logic        expValid = 0, expAllow = 0, expDeny = 0;
  logic [63:0] expStatus = 0, expAddr = 0;
  string       expTag = "R1";

  always @(posedge clk) begin
    logic [31:0] code;
    logic        isF, isS;
    string       tag;
    if (!rstN) begin
      expValid <= 0; expAllow <= 0; expDeny <= 0; expStatus <= 0; expAddr <= 0; expTag <= "R1";
    end else if (!reqValid) begin
      expValid <= 0; expAllow <= 0; expDeny <= 0; expStatus <= 0; expAddr <= 0; expTag <= "R2";
    end else begin
      isF = (reqKind >= 2);
      isS = (reqKind == 1);
      code = 0;
      tag = "R9";
      if (!pteValid) begin
        code = 32'h4000_0000 | (isS ? 32'h0200_0000 : 32'h0); tag = "R7";
      end else if (pteAttr[3] && userMode) begin
        code = isF ? 32'h1000_0000 : (isS ? 32'h0A00_0000 : 32'h0800_0000); tag = "R8";
      end else if (isF) begin
        if (!pteAttr[0]) begin code = 32'h1000_0000; tag = "R6"; end
        else if (!pteAttr[8]) begin code = 32'h0004_0000; tag = "R6"; end
      end else if (isS) begin
        if (!pteAttr[1]) begin code = 32'h0A00_0000; tag = "R4"; end
        else if (!pteAttr[8] || !pteAttr[7]) begin code = 32'h0204_0000; tag = "R5"; end
      end else begin
        if (!pteAttr[2]) begin code = 32'h0800_0000; tag = "R3"; end
        else if (!pteAttr[8]) begin code = 32'h0004_0000; tag = "R5"; end
      end
      expValid <= 1;
      expAllow <= (code == 0);
      expDeny  <= (code != 0);
      expStatus <= (code == 0) ? 64'h0 : ({32'h0, code} | (isF ? msrBits : 64'h0));
      expAddr  <= (code == 0) ? 64'h0 :
                  (reqNextPage ? (((reqAddr >> 12) << 12) + 64'h1000) : reqAddr);
      expTag   <= tag;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    checks++;
    if (rspValid !== expValid || rspAllow !== expAllow || rspDeny !== expDeny ||
        rspStatus !== expStatus) begin
      errors++;
      $display("FAIL %s (phase %s): valid/allow/deny/status = %0b/%0b/%0b/%h expected %0b/%0b/%0b/%h",
               expTag, phase, rspValid, rspAllow, rspDeny, rspStatus,
               expValid, expAllow, expDeny, expStatus);
    end else if (rspFaultAddr !== expAddr) begin
      errors++;
      $display("FAIL R10 (phase %s): fault address %h expected %h", phase, rspFaultAddr, expAddr);
    end
  end

  task automatic drive(input logic v, input logic [1:0] k, input logic pv, input logic [8:0] a,
                       input logic u, input logic nx, input logic [63:0] ad, input logic [63:0] m);
    @(negedge clk);
    reqValid = v; reqKind = k; pteValid = pv; pteAttr = a;
    userMode = u; reqNextPage = nx; reqAddr = ad; msrBits = m;
  endtask

  // attribute shorthands
  localparam logic [8:0] A_EX = 9'h001, A_WR = 9'h002, A_RD = 9'h004, A_PRIV = 9'h008;
  localparam logic [8:0] A_NC = 9'h020, A_CHG = 9'h080, A_REF = 9'h100;
  localparam logic [8:0] A_DATA = A_RD | A_WR | A_REF | A_CHG;

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish, checks %0d expected completion", checks);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    phase = "R1";
    repeat (4) @(negedge clk);
    // R1: explicit reset-state check
    checks++;
    if (rspValid !== 0 || rspAllow !== 0 || rspDeny !== 0 || rspStatus !== 0 || rspFaultAddr !== 0) begin
      errors++;
      $display("FAIL R1: outputs %0b/%0b/%0b/%h/%h expected all zero",
               rspValid, rspAllow, rspDeny, rspStatus, rspFaultAddr);
    end
    @(negedge clk); rstN = 1;

    phase = "R2";
    drive(0, 0, 1, A_DATA, 0, 0, 64'h124000, MSR_RUN);
    drive(0, 0, 1, A_DATA, 0, 0, 64'h124000, MSR_RUN);

    phase = "R7";
    drive(1, 0, 0, 0, 0, 0, 64'h123000, MSR_RUN);
    drive(1, 1, 0, 0, 0, 0, 64'h123008, MSR_RUN);
    drive(1, 2, 0, 0, 0, 0, 64'h523000, MSR_RUN);

    phase = "R9";
    drive(1, 0, 1, A_DATA, 0, 0, 64'h124108, MSR_RUN);
    drive(1, 1, 1, A_DATA, 0, 0, 64'h10b0d8, MSR_RUN);
    drive(1, 2, 1, A_EX | A_REF, 0, 0, 64'h324000, MSR_RUN);
    drive(1, 3, 1, A_EX | A_REF, 0, 0, 64'h1324000, MSR_RUN);

    phase = "R3";
    drive(1, 0, 1, A_REF, 0, 0, 64'h124000, MSR_RUN);
    drive(1, 0, 1, A_WR | A_REF | A_CHG, 0, 0, 64'h124000, MSR_RUN);

    phase = "R4";
    drive(1, 1, 1, A_REF, 0, 0, 64'h124000, MSR_RUN);
    drive(1, 1, 1, A_RD | A_REF, 0, 0, 64'h124000, MSR_RUN);
    drive(1, 1, 1, 9'h000, 0, 0, 64'h124000, MSR_RUN);

    phase = "R5";
    drive(1, 0, 1, A_RD | A_WR, 0, 0, 64'h124000, MSR_RUN);
    drive(1, 1, 1, A_RD | A_WR, 0, 0, 64'h124000, MSR_RUN);
    drive(1, 1, 1, A_RD | A_WR | A_REF, 0, 0, 64'h124000, MSR_RUN);
    drive(1, 0, 1, A_RD | A_WR | A_REF, 0, 0, 64'h124000, MSR_RUN);

    phase = "R6";
    drive(1, 2, 1, A_DATA, 0, 0, 64'h324000, MSR_RUN);
    drive(1, 2, 1, A_EX, 0, 0, 64'h349000, MSR_RUN);
    drive(1, 2, 1, 9'h000, 0, 0, 64'h349000, MSR_RUN);
    drive(1, 2, 1, 9'h000, 0, 0, 64'h349000, 64'h0);

    phase = "R8";
    drive(1, 0, 1, A_DATA | A_PRIV, 1, 0, 64'h124000, MSR_RUN);
    drive(1, 1, 1, A_DATA | A_PRIV, 1, 0, 64'h124000, MSR_RUN);
    drive(1, 2, 1, A_EX | A_REF | A_PRIV, 1, 0, 64'h324000, MSR_RUN);
    drive(1, 0, 1, A_DATA | A_PRIV, 0, 0, 64'h124000, MSR_RUN);

    phase = "R10";
    drive(1, 0, 0, 0, 0, 1, 64'h39fffd, MSR_RUN);
    drive(1, 1, 0, 0, 0, 1, 64'h39fffd, MSR_RUN);
    drive(1, 2, 0, 0, 0, 1, 64'h30affc, MSR_RUN);
    drive(1, 2, 1, A_RD | A_REF, 0, 1, 64'h30affc, MSR_RUN);
    drive(1, 0, 0, 0, 0, 1, 64'hffff_ffff_ffff_fffd, MSR_RUN);
    drive(1, 0, 1, A_DATA, 0, 1, 64'h39fffd, MSR_RUN);

    phase = "R11";
    drive(1, 0, 1, A_DATA | A_NC | 9'h050, 0, 0, 64'h124000, MSR_RUN);
    drive(1, 1, 1, A_RD | A_REF | A_NC | 9'h050, 0, 0, 64'h124000, MSR_RUN);
    drive(1, 2, 1, A_EX | A_NC, 0, 0, 64'h349000, MSR_RUN);

    phase = "R2";
    drive(0, 2, 0, 0, 0, 1, 64'h1, MSR_RUN);

    phase = "random";
    for (int i = 0; i < 3000; i++) begin
      drive(($urandom % 8) != 0, 2'($urandom), ($urandom % 6) != 0, 9'($urandom),
            1'($urandom), 1'($urandom), {$urandom, $urandom}, {$urandom, $urandom});
    end

    drive(0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule